// File: doc/BRIEF.md
# Asymmetric Digital Baseline Restorer

This block removes the slowly wandering DC level from a stream of signed samples that come out of a pulse-shaping filter. It keeps a running estimate of the baseline in fixed point, with eight fractional bits. On each accepted sample it moves the estimate toward that sample by a slew-limited step. Upward and downward movement each have their own 2-bit rate select, so the correction is asymmetric. With a slow upward rate and a fast downward rate, the estimate rests on the negative-going noise troughs. Those troughs occur only when no pulse is present. A settled estimate therefore sits about one rms noise level below the true mean, and the pulse tails have little effect on it.

A pulse-busy flag from a fast discriminator freezes the estimate while a pulse is in flight. The freeze lasts for a programmable number of accepted samples after the flag falls, which keeps the tail of the pulse out of the baseline. Each accepted sample leaves the block one clock later with the integer part of the estimate subtracted. The current integer estimate is always visible on a port. After reset, the first accepted sample seeds the estimate directly, so the block does not need a long settling time.

Top module: `blr_core`

## Requirements
- R1: While reset is asserted and after it is released, before any sample arrives, `out_valid` is 0, `out_sample` is 0 and `base_est` is 0.
- R2: The first sample accepted after reset sets the estimate to exactly that sample, whatever `busy` and the rate selects are. Its corrected output is 0.
- R3: A sample accepted on `in_valid` produces `out_valid` = 1 on the next clock. `out_sample` is then the sample minus the floor of the estimate as it stood before that sample's update, computed one bit wider than the input.
- R4: When the sample lies above the estimate, the estimate in 1/256 LSB units rises by |err| >> up_shift. Here err = sample*256 − estimate, and up_shift is decoded from `up_rate`.
- R5: When the sample lies below the estimate, the estimate falls by |err| >> dn_shift, with dn_shift decoded from `dn_rate`.
- R6: Rate select decode: code 0 gives a shift of 8 (slowest), code 1 gives 6, code 2 gives 4, code 3 gives 2 (fastest).
- R7: When err is nonzero and the shifted step would be 0, the step is exactly 1/256 LSB in the direction of err. When err is zero, the estimate does not change.
- R8: An accepted sample that arrives while `busy` is 1 leaves the estimate unchanged, although it is still corrected and output.
- R9: Every cycle with `busy` = 1 reloads a hold-off count from `hold_len`. After `busy` falls, the next `hold_len` accepted samples leave the estimate unchanged. The sample after them updates it again, and `hold_len` = 0 resumes updates at once.
- R10: A single update never carries the estimate past the sample that drove it.
- R11: A cycle with `in_valid` = 0 gives `out_valid` = 0 on the next clock and leaves `base_est` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | W | Signed shaped sample |
| busy | input | 1 | Pulse in progress, from the fast discriminator |
| up_rate | input | 2 | Upward slew select (0 slowest, 3 fastest) |
| dn_rate | input | 2 | Downward slew select (0 slowest, 3 fastest) |
| hold_len | input | HOLD_W | Samples of freeze after busy falls |
| out_valid | output | 1 | Corrected sample strobe |
| out_sample | output | W+1 | Signed corrected sample |
| base_est | output | W | Integer part of the current estimate, signed |

## Verification
The freeze logic and the slew update act on the same accepted sample. The hold-off count can expire on the very sample that would otherwise apply a large step. A busy reload can also land in a cycle with no valid sample, and that reload must still extend the freeze. The bench drives busy pulses with hold lengths of 0 and 3, and it inserts strobe gaps that carry busy. It compares `base_est` sample by sample against an independent fixed-point model, so an update that arrives one sample early or late shows up as a mismatch. The minimum-step rule and the floor used in the correction also interact: only the 1/256 creep can lift the integer estimate at the slowest rate, and that crossing is checked on the exact sample where it happens.

// File: rtl/blr_pkg.sv
package blr_pkg;

    // Slew rate selects, slowest first.
    typedef enum logic [1:0] {
        RATE_CRAWL = 2'd0,
        RATE_LOW   = 2'd1,
        RATE_MID   = 2'd2,
        RATE_HIGH  = 2'd3
    } rate_code_t;

    // Direction index into per-direction arrays.
    localparam int DIR_UP = 0;
    localparam int DIR_DN = 1;
    localparam int N_DIR  = 2;

endpackage

// File: rtl/blr_rate_dec.sv
module blr_rate_dec
    import blr_pkg::*;
#(
    parameter int SHIFT_MAX  = 8,
    parameter int SHIFT_STEP = 2,
    parameter int SH_W       = 4
) (
    input  rate_code_t       code,
    output logic [SH_W-1:0]  shift
);

    localparam logic [SH_W-1:0] MAX_L  = SH_W'(SHIFT_MAX);
    localparam logic [SH_W-1:0] STEP_L = SH_W'(SHIFT_STEP);

    logic [SH_W-1:0] code_ext;

    always_comb begin
        code_ext = SH_W'(code);
        // Faster code -> smaller right shift -> larger step.
        shift    = MAX_L - STEP_L * code_ext;
    end

endmodule

// File: rtl/blr_step.sv
module blr_step #(
    parameter int EW   = 25,
    parameter int SH_W = 4
) (
    input  logic signed [EW-1:0] err,
    input  logic [SH_W-1:0]      up_sh,
    input  logic [SH_W-1:0]      dn_sh,
    output logic signed [EW-1:0] delta
);

    logic            neg;
    logic [EW-1:0]   mag;
    logic [EW-1:0]   scaled;
    logic [SH_W-1:0] sh;

    always_comb begin
        neg = err[EW-1];
        mag = neg ? (~err + 1'b1) : err;
        sh  = neg ? dn_sh : up_sh;
        scaled = mag >> sh;
        // Never stall: any nonzero error moves at least one fractional LSB.
        if ((mag != '0) && (scaled == '0)) begin
            scaled = EW'(1);
        end
        delta = neg ? -$signed(scaled) : $signed(scaled);
    end

endmodule

// File: rtl/blr_hold.sv
module blr_hold #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              in_valid,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              frozen
);

    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
    } hold_state_t;

    hold_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (busy) begin
            state_d.cnt = hold_len;
        end else if (in_valid && (state_q.cnt != '0)) begin
            state_d.cnt = state_q.cnt - 1'b1;
        end
        frozen = busy || (state_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/blr_core.sv
module blr_core
    import blr_pkg::*;
#(
    parameter int W          = 16,
    parameter int FRAC       = 8,
    parameter int HOLD_W     = 8,
    parameter int SHIFT_MAX  = 8,
    parameter int SHIFT_STEP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [W-1:0]        in_sample,
    input  logic                busy,
    input  logic [1:0]          up_rate,
    input  logic [1:0]          dn_rate,
    input  logic [HOLD_W-1:0]   hold_len,
    output logic                out_valid,
    output logic [W:0]          out_sample,
    output logic [W-1:0]        base_est
);

    localparam int ESTW = W + FRAC;
    localparam int EW   = ESTW + 1;
    localparam int SH_W = $clog2(SHIFT_MAX + 1);

    typedef struct packed {
        logic            primed;
        logic [ESTW-1:0] est;
        logic            ovalid;
        logic [W:0]      osample;
    } core_state_t;

    core_state_t state_d, state_q;

    logic [SH_W-1:0]      shift_dir [N_DIR];
    rate_code_t           code_dir  [N_DIR];
    logic signed [EW-1:0] s_fx;
    logic signed [EW-1:0] est_ext;
    logic signed [EW-1:0] err;
    logic signed [EW-1:0] delta;
    logic                 frozen;
    logic                 primed;
    logic [W-1:0]         est_int;

    assign code_dir[DIR_UP] = rate_code_t'(up_rate);
    assign code_dir[DIR_DN] = rate_code_t'(dn_rate);

    for (genvar g = 0; g < N_DIR; g++) begin : g_dec
        blr_rate_dec #(
            .SHIFT_MAX (SHIFT_MAX),
            .SHIFT_STEP(SHIFT_STEP),
            .SH_W      (SH_W)
        ) i_dec (
            .code (code_dir[g]),
            .shift(shift_dir[g])
        );
    end

    blr_hold #(.HOLD_W(HOLD_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .in_valid(in_valid),
        .hold_len(hold_len),
        .frozen  (frozen)
    );

    blr_step #(.EW(EW), .SH_W(SH_W)) i_step (
        .err  (err),
        .up_sh(shift_dir[DIR_UP]),
        .dn_sh(shift_dir[DIR_DN]),
        .delta(delta)
    );

    always_comb begin
        est_int = state_q.est[ESTW-1:FRAC];
        s_fx    = {in_sample[W-1], in_sample, {FRAC{1'b0}}};
        est_ext = {state_q.est[ESTW-1], state_q.est};
        err     = s_fx - est_ext;

        state_d        = state_q;
        state_d.ovalid = in_valid;
        if (in_valid) begin
            if (!state_q.primed) begin
                // Seed from the first sample: immediate start-up.
                state_d.primed  = 1'b1;
                state_d.est     = s_fx[ESTW-1:0];
                state_d.osample = '0;
            end else begin
                state_d.osample = {in_sample[W-1], in_sample} - {est_int[W-1], est_int};
                if (!frozen) begin
                    state_d.est = state_q.est + delta[ESTW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign primed     = state_q.primed;
    assign out_valid  = state_q.ovalid;
    assign out_sample = state_q.osample;
    assign base_est   = est_int;

endmodule

// File: rtl/blr_checker.sv
module blr_checker #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic signed [W-1:0] in_sample,
    input logic                busy,
    input logic                frozen,
    input logic                primed,
    input logic                out_valid,
    input logic signed [W-1:0] base_est
);

    // R3: accepted sample appears one clock later
    a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11: idle cycle produces nothing and holds the estimate
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(base_est)));

    // R8: busy samples do not move the estimate
    a_r8_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && primed && busy) |=> $stable(base_est));

    // R9: hold-off window also freezes the estimate
    a_r9_holdoff_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && primed && frozen) |=> $stable(base_est));

    // R10: upward update stops at the sample
    a_r10_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && primed && (in_sample >= base_est)) |=> (base_est <= $past(in_sample)));

    // R10: downward update stops at the sample
    a_r10_no_overshoot_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && primed && (in_sample < base_est)) |=> (base_est >= $past(in_sample)));

endmodule

bind blr_core blr_checker #(.W(W)) i_blr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .busy     (busy),
    .frozen   (frozen),
    .primed   (primed),
    .out_valid(out_valid),
    .base_est (base_est)
);

// File: tb/test_blr_core.sv
`timescale 1ns/1ps
module test_blr_core;

    localparam int W      = 16;
    localparam int HOLD_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [W-1:0]      in_sample = '0;
    logic              busy = 1'b0;
    logic [1:0]        up_rate = 2'd0;
    logic [1:0]        dn_rate = 2'd0;
    logic [HOLD_W-1:0] hold_len = '0;
    logic              out_valid;
    logic [W:0]        out_sample;
    logic [W-1:0]      base_est;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Independent model state, estimate in 1/256 units.
    longint m_est;
    bit     m_primed;
    int     m_hold;

    always #2 clk = ~clk;   // 250 MHz

    blr_core i_blr_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .busy(busy), .up_rate(up_rate), .dn_rate(dn_rate), .hold_len(hold_len),
        .out_valid(out_valid), .out_sample(out_sample), .base_est(base_est)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int shift_of(input int code);
        return 8 - 2 * code;   // R6
    endfunction

    longint base_now;

    // Drive one cycle and compare outputs after the edge.
    task automatic cyc(input longint s, input bit b, input bit v, input string tag);
        longint exp_out, err, mag, st;
        bit     frz;
        @(negedge clk);
        in_sample = W'(s);
        busy      = b;
        in_valid  = v;
        @(posedge clk);
        exp_out = 0;
        frz = b || (m_hold != 0);
        if (v) begin
            if (!m_primed) begin
                m_primed = 1'b1;
                m_est    = s * 256;
            end else begin
                exp_out = s - (m_est >>> 8);
                if (!frz) begin
                    err = s * 256 - m_est;
                    mag = (err < 0) ? -err : err;
                    st  = mag >> shift_of((err < 0) ? int'(dn_rate) : int'(up_rate));
                    if (mag != 0 && st == 0) st = 1;
                    m_est = m_est + ((err < 0) ? -st : st);
                end
            end
        end
        if (b) m_hold = int'(hold_len);
        else if (v && m_hold > 0) m_hold--;
        #1;
        base_now = longint'($signed(base_est));
        chk({tag, " R3 valid"}, longint'(out_valid), longint'(v));
        if (v) chk({tag, " R3 out"}, longint'($signed(out_sample)), exp_out);
        chk({tag, " base"}, base_now, m_est >>> 8);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; busy = 1'b0;
        m_est = 0; m_primed = 1'b0; m_hold = 0;
        @(negedge clk);
        chk("R1 valid", longint'(out_valid), 0);
        chk("R1 out", longint'($signed(out_sample)), 0);
        chk("R1 base", longint'($signed(base_est)), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 base after release", longint'($signed(base_est)), 0);
    endtask

    task automatic t_init();
        do_reset();
        up_rate = 2'd0; dn_rate = 2'd0; hold_len = 8'd5;
        cyc(1000, 1'b1, 1'b1, "R2 seed");
        chk("R2 seed base", base_now, 1000);
        chk("R2 seed out", longint'($signed(out_sample)), 0);
        cyc(1010, 1'b1, 1'b1, "R8 busy after seed");
        chk("R8 frozen base", base_now, 1000);
        chk("R3 corrected", longint'($signed(out_sample)), 10);
    endtask

    task automatic t_rate_codes();
        longint exp_up[4] = '{1, 4, 16, 64};
        for (int c = 0; c < 4; c++) begin
            do_reset();
            up_rate = 2'(c); dn_rate = 2'd0; hold_len = '0;
            cyc(0, 1'b0, 1'b1, "R2 seed0");
            cyc(256, 1'b0, 1'b1, "R4 up");
            chk($sformatf("R6 up code %0d", c), base_now, exp_up[c]);
            do_reset();
            up_rate = 2'd0; dn_rate = 2'(c);
            cyc(0, 1'b0, 1'b1, "R2 seed0");
            cyc(-256, 1'b0, 1'b1, "R5 dn");
            chk($sformatf("R5 dn code %0d", c), base_now, -exp_up[c]);
        end
    endtask

    task automatic t_min_step();
        do_reset();
        up_rate = 2'd3; dn_rate = 2'd3; hold_len = '0;
        cyc(0, 1'b0, 1'b1, "R2 seed");
        cyc(1, 1'b0, 1'b1, "R4 frac");   // estimate 64/256
        up_rate = 2'd0;
        for (int i = 0; i < 191; i++) cyc(1, 1'b0, 1'b1, "R7 creep");
        chk("R7 before crossing", base_now, 0);
        cyc(1, 1'b0, 1'b1, "R7 creep");
        chk("R7 crossing", base_now, 1);
        for (int i = 0; i < 4; i++) cyc(1, 1'b0, 1'b1, "R7 zero err");
        chk("R7 zero error stable", base_now, 1);
        chk("R7 zero error out", longint'($signed(out_sample)), 0);
    endtask

    task automatic t_converge();
        do_reset();
        up_rate = 2'd2; dn_rate = 2'd2; hold_len = '0;
        cyc(0, 1'b0, 1'b1, "R2 seed");
        for (int i = 0; i < 300; i++) begin
            cyc(500, 1'b0, 1'b1, "R10 rise");
            if (base_now > 500) chk("R10 overshoot up", base_now, 500);
        end
        chk("R10 settled up", base_now, 500);
        for (int i = 0; i < 300; i++) begin
            cyc(-300, 1'b0, 1'b1, "R10 fall");
            if (base_now < -300) chk("R10 overshoot dn", base_now, -300);
        end
        chk("R10 settled dn", base_now, -300);
    endtask

    task automatic t_holdoff();
        longint b0;
        do_reset();
        up_rate = 2'd3; dn_rate = 2'd3; hold_len = 8'd3;
        cyc(0, 1'b0, 1'b1, "R2 seed");
        cyc(2000, 1'b1, 1'b1, "R8 busy");
        chk("R8 busy base", base_now, 0);
        for (int i = 0; i < 3; i++) begin
            cyc(2000, 1'b0, 1'b1, "R9 hold");
            chk("R9 held", base_now, 0);
        end
        cyc(2000, 1'b0, 1'b1, "R9 resume");
        chk("R9 resumed", base_now, 500);
        b0 = base_now;
        hold_len = 8'd0;
        cyc(2000, 1'b1, 1'b1, "R8 busy2");
        chk("R8 busy2 base", base_now, b0);
        cyc(2000, 1'b0, 1'b1, "R9 zero hold");
        chk("R9 zero hold resumes", base_now, b0 + (((2000 - b0) * 256) >> 2) / 256);
        // Busy in a strobe gap still arms the hold-off.
        hold_len = 8'd2;
        b0 = base_now;
        cyc(0, 1'b1, 1'b0, "R11 gap busy");
        chk("R11 gap no valid", longint'(out_valid), 0);
        chk("R11 gap base", base_now, b0);
        cyc(2000, 1'b0, 1'b0, "R11 gap");
        cyc(2000, 1'b0, 1'b1, "R9 gap hold1");
        cyc(2000, 1'b0, 1'b1, "R9 gap hold2");
        chk("R9 gap held", base_now, b0);
        cyc(2000, 1'b0, 1'b1, "R9 gap resume");
    endtask

    task automatic t_noise();
        logic [15:0] lfsr = 16'hACE1;
        longint s;
        do_reset();
        up_rate = 2'd0; dn_rate = 2'd3; hold_len = 8'd4;
        cyc(100, 1'b0, 1'b1, "R2 seed");
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = 100 + longint'($signed({1'b0, lfsr[4:0]})) - 16;
            if (lfsr[15:12] == 4'hF) s = s + 3000;
            if (i == 1000) begin up_rate = 2'd1; dn_rate = 2'd2; end
            cyc(s, lfsr[11:9] == 3'b111, lfsr[8:6] != 3'b000, "R4 R5 noise");
        end
        if (base_now > 100) chk("R4 asymmetric rests low", base_now, 100);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_init();
        t_rate_codes();
        t_min_step();
        t_converge();
        t_holdoff();
        t_noise();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule